// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

This block fetches a small set of configuration words (I/O base, interrupt choice, station address and similar) from a three-wire serial EEPROM. It drives chip select, shift clock and serial data out, and it reads serial data back. At power-on reset it fills the configuration register file through a simple write port. On command from the CPU it can store the configuration back to the EEPROM or load it again. A select bit turns both commands into a single-word move between the EEPROM and a pair of general-purpose registers, so software can read or program any EEPROM word without disturbing the live configuration.

Three area-select pins choose which group of eight EEPROM words holds the setup. One area-select value replaces the first two words with built-in defaults. The shift clock is derived from the core clock. With the default divider of 200 at 100 MHz its period is 4 µs, so a five-word reload takes about 5 × 25 × 4 µs = 500 µs. An enable pin held low keeps the block from ever touching the EEPROM. While an operation runs, the CPU can only poll the control register.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: After hardware reset is released with `ee_en` high, a full reload starts on the first clock edge. The control register (`cpu_addr`=0) then reads bit0=1 until the reload completes.
- R2: A reload issues one read frame per word, for index 0 to NWORDS-1. Each frame is the start bit 1, opcode 10, the 6-bit address {area_sel, index[2:0]} MSB first, then 16 clock periods during which data is captured MSB first. Each word appears on `cfg_wdata` with a one-cycle `cfg_we` pulse at `cfg_idx`, in index order.
- R3: When `area_sel` equals DFLT_SEL (3'b111), index 0 is written as DFLT_BASE (16'h0300) and index 1 as DFLT_IRQ (16'h0002), whatever the EEPROM holds. The other indices carry EEPROM data.
- R4: The shift clock high and low phases each last CLK_DIV core cycles. `ee_sk` is high only while `ee_cs` is high. `ee_di` does not change while `ee_sk` is high.
- R5: A store writes `cfg_rdata[cfg_idx]` for every index to address {area_sel, index}. Each write frame (1, 01, address, 16 data bits) is preceded by a write-enable frame (1, 00, 11 followed by four zeros). Before the next word is sent, the block holds `ee_cs` high until `ee_do` reads 1 (ready).
- R6: Control bit0 (reload) and bit1 (store) start an operation when written as 1 and read 1 until it completes. If both are written at once, only the reload runs.
- R7: While an operation runs, writes to any register are ignored. Reads of `cpu_addr` 1 and 2 return 0.
- R8: With control bit2 (word mode) set, a reload copies the EEPROM word at the general-purpose address (`cpu_addr`=2, bits 5:0) into the general-purpose data register (`cpu_addr`=1). A store writes that data register to that address. Neither drives `cfg_we`.
- R9: With `ee_en` low, `ee_cs` never rises. The reset reload is skipped, and written reload or store bits have no effect and read 0.
- R10: A `soft_rst` pulse while idle clears word mode and both general-purpose registers. It does not start any EEPROM transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Hardware reset, active low; triggers a reload |
| soft_rst | input | 1 | Software reset pulse; no reload |
| ee_en | input | 1 | EEPROM present; low forbids any access |
| area_sel | input | 3 | Setup area select |
| cpu_addr | input | 2 | Register select: 0 control, 1 word data, 2 word address |
| cpu_wr | input | 1 | One-cycle register write strobe |
| cpu_wdata | input | 16 | Register write data |
| cpu_rdata | output | 16 | Register read data (combinational) |
| cfg_we | output | 1 | Configuration write strobe |
| cfg_idx | output | 3 | Configuration word index (write and read) |
| cfg_wdata | output | 16 | Configuration write data |
| cfg_rdata | input | 16 | Configuration word at `cfg_idx`, used by store |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM shift clock |
| ee_di | output | 1 | Serial data to EEPROM |
| ee_do | input | 1 | Serial data / ready from EEPROM |

## Verification
The assertions assume that `ee_en` and `area_sel` change only while the block is idle or in reset. They also assume `cpu_wr` is a single-cycle strobe and that `ee_do` answers with a ready level of 1 when the EEPROM is not programming. The bench follows these rules: pins are changed only after polling shows the control bits clear, or while reset is held. The EEPROM model updates `ee_do` on rising `ee_sk` and pulls it low for a fixed programming time after each accepted write. Random area choices and memory contents are mixed with directed cases for the default area, word mode, lockout, simultaneous command bits, soft reset and a disabled EEPROM.

// File: rtl/eecfg_pkg.sv
package eecfg_pkg;
  localparam int EE_AW   = 6;
  localparam int EE_DW   = 16;
  localparam int SEL_W   = 3;
  localparam int FRAME_W = 3 + EE_AW + EE_DW;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  typedef logic [FRAME_W-1:0] frame_t;

  // read: start 1, opcode 10, address, then idle data slots
  function automatic frame_t mk_read(input logic [EE_AW-1:0] a);
    return {3'b110, a, {EE_DW{1'b0}}};
  endfunction

  // write: start 1, opcode 01, address, data
  function automatic frame_t mk_write(input logic [EE_AW-1:0] a, input logic [EE_DW-1:0] d);
    return {3'b101, a, d};
  endfunction

  // write enable: start 1, opcode 00, address field 11xxxx
  function automatic frame_t mk_wen();
    return {3'b100, 2'b11, {(EE_AW-2){1'b0}}, {EE_DW{1'b0}}};
  endfunction

  // configuration value after default substitution
  function automatic logic [EE_DW-1:0] pick_cfg(
    input logic [SEL_W-1:0] sel, input logic [SEL_W-1:0] dsel,
    input int unsigned idx, input logic [EE_DW-1:0] word,
    input logic [EE_DW-1:0] dbase, input logic [EE_DW-1:0] dirq);
    if (sel == dsel && idx == 0) return dbase;
    if (sel == dsel && idx == 1) return dirq;
    return word;
  endfunction
endpackage

// File: rtl/ee_tick.sv
module ee_tick #(
  parameter int CLK_DIV = 200
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);

  AST_TICK_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R4
endmodule

// File: rtl/ee_shift.sv
module ee_shift
  import eecfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic             poll,
  input  frame_t           frame,
  input  logic [CNT_W-1:0] nbits,
  input  logic             din,
  output logic             idle,
  output logic             done,
  output logic [EE_DW-1:0] rx,
  output logic             cs,
  output logic             sk,
  output logic             di
);
  typedef enum logic [2:0] {S_IDLE, S_CSUP, S_LO, S_HI, S_POLL, S_GAP} sh_st_e;

  sh_st_e           st;
  frame_t           sreg;
  logic [CNT_W-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sreg <= '0; left <= '0; rx <= '0;
      cs <= 1'b0; sk <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          sreg <= poll ? '0 : frame;
          left <= nbits;
          st   <= poll ? S_POLL : S_CSUP;
        end
        S_CSUP: if (tick) begin cs <= 1'b1; st <= S_LO; end
        S_LO:   if (tick) begin sk <= 1'b1; st <= S_HI; end
        S_HI: if (tick) begin
          sk   <= 1'b0;
          rx   <= {rx[EE_DW-2:0], din};
          sreg <= sreg << 1;
          if (left == CNT_W'(1)) begin cs <= 1'b0; st <= S_GAP; end
          else begin left <= left - 1'b1; st <= S_LO; end
        end
        S_POLL: if (tick) begin
          if (!cs) cs <= 1'b1;
          else if (din) begin cs <= 1'b0; st <= S_GAP; end
        end
        S_GAP: if (tick) begin done <= 1'b1; st <= S_IDLE; end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign di   = cs & sreg[FRAME_W-1];
  assign idle = (st == S_IDLE);

  AST_SK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    sk |-> cs); // R4
  AST_DI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sk && $past(sk)) |-> $stable(di)); // R4
endmodule

// File: rtl/ee_seq.sv
module ee_seq
  import eecfg_pkg::*;
#(
  parameter int               NWORDS    = 5,
  parameter logic [SEL_W-1:0] DFLT_SEL  = '1,
  parameter logic [EE_DW-1:0] DFLT_BASE = 16'h0300,
  parameter logic [EE_DW-1:0] DFLT_IRQ  = 16'h0002,
  localparam int IDX_W = EE_AW - SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             go_store,
  input  logic             go_word,
  input  logic [SEL_W-1:0] area,
  input  logic [EE_AW-1:0] w_addr,
  input  logic [EE_DW-1:0] w_data,
  input  logic [EE_DW-1:0] cfg_rdata,
  output logic             busy,
  output logic             done,
  output logic             cfg_we,
  output logic [IDX_W-1:0] cfg_idx,
  output logic [EE_DW-1:0] cfg_wdata,
  output logic             wrd_we,
  output logic [EE_DW-1:0] wrd_data,
  output logic             sh_start,
  output logic             sh_poll,
  output frame_t           sh_frame,
  output logic [CNT_W-1:0] sh_nbits,
  input  logic             sh_done,
  input  logic [EE_DW-1:0] sh_rx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NWORDS - 1);

  typedef enum logic [3:0] {
    Q_IDLE, Q_RD, Q_RDW, Q_WEN, Q_WENW, Q_WR, Q_WRW, Q_POLL, Q_POLLW, Q_NEXT
  } q_st_e;

  q_st_e            st;
  logic             store_l, word_l;
  logic [SEL_W-1:0] area_l;
  logic [EE_AW-1:0] waddr_l;
  logic [EE_DW-1:0] wdata_l;
  logic [IDX_W-1:0] idx;
  logic [EE_AW-1:0] addr_cur;
  logic [EE_DW-1:0] data_cur;

  assign addr_cur = word_l ? waddr_l : {area_l, idx};
  assign data_cur = word_l ? wdata_l : cfg_rdata;
  assign cfg_idx  = idx;
  assign busy     = (st != Q_IDLE);
  assign done     = (st == Q_NEXT) && (word_l || idx == LAST_IDX);

  always_comb begin
    sh_start = 1'b0;
    sh_poll  = 1'b0;
    sh_frame = '0;
    sh_nbits = CNT_W'(FRAME_W);
    case (st)
      Q_RD:   begin sh_start = 1'b1; sh_frame = mk_read(addr_cur); end
      Q_WEN:  begin sh_start = 1'b1; sh_frame = mk_wen(); sh_nbits = CNT_W'(3 + EE_AW); end
      Q_WR:   begin sh_start = 1'b1; sh_frame = mk_write(addr_cur, data_cur); end
      Q_POLL: begin sh_start = 1'b1; sh_poll = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= Q_IDLE; store_l <= 1'b0; word_l <= 1'b0; area_l <= '0;
      waddr_l <= '0; wdata_l <= '0; idx <= '0;
      cfg_we <= 1'b0; cfg_wdata <= '0; wrd_we <= 1'b0; wrd_data <= '0;
    end else begin
      cfg_we <= 1'b0;
      wrd_we <= 1'b0;
      case (st)
        Q_IDLE: if (go) begin
          store_l <= go_store; word_l <= go_word; area_l <= area;
          waddr_l <= w_addr;   wdata_l <= w_data; idx <= '0;
          st <= go_store ? Q_WEN : Q_RD;
        end
        Q_RD:   st <= Q_RDW;
        Q_RDW: if (sh_done) begin
          if (word_l) begin wrd_we <= 1'b1; wrd_data <= sh_rx; end
          else begin
            cfg_we    <= 1'b1;
            cfg_wdata <= pick_cfg(area_l, DFLT_SEL, int'(idx), sh_rx, DFLT_BASE, DFLT_IRQ);
          end
          st <= Q_NEXT;
        end
        Q_WEN:   st <= Q_WENW;
        Q_WENW:  if (sh_done) st <= Q_WR;
        Q_WR:    st <= Q_WRW;
        Q_WRW:   if (sh_done) st <= Q_POLL;
        Q_POLL:  st <= Q_POLLW;
        Q_POLLW: if (sh_done) st <= Q_NEXT;
        Q_NEXT: begin
          if (done) st <= Q_IDLE;
          else begin
            idx <= idx + 1'b1;
            st  <= store_l ? Q_WEN : Q_RD;
          end
        end
        default: st <= Q_IDLE;
      endcase
    end
  end

  AST_WORD_NO_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && word_l) |-> !cfg_we); // R8
endmodule

// File: rtl/eeprom_cfg_loader.sv
module eeprom_cfg_loader
  import eecfg_pkg::*;
#(
  parameter int               CLK_DIV   = 200,
  parameter int               NWORDS    = 5,
  parameter logic [SEL_W-1:0] DFLT_SEL  = '1,
  parameter logic [EE_DW-1:0] DFLT_BASE = 16'h0300,
  parameter logic [EE_DW-1:0] DFLT_IRQ  = 16'h0002,
  localparam int IDX_W = EE_AW - SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             ee_en,
  input  logic [SEL_W-1:0] area_sel,
  input  logic [1:0]       cpu_addr,
  input  logic             cpu_wr,
  input  logic [EE_DW-1:0] cpu_wdata,
  output logic [EE_DW-1:0] cpu_rdata,
  output logic             cfg_we,
  output logic [IDX_W-1:0] cfg_idx,
  output logic [EE_DW-1:0] cfg_wdata,
  input  logic [EE_DW-1:0] cfg_rdata,
  output logic             ee_cs,
  output logic             ee_sk,
  output logic             ee_di,
  input  logic             ee_do
);
  logic             boot_q, rl_flag, st_flag, wmode_q;
  logic [EE_DW-1:0] wdata_q;
  logic [EE_AW-1:0] waddr_q;
  logic             busy, cpu_ok, wr_ctrl, go_rl, go_st, go_word;
  logic             eng_busy, eng_done, wrd_we;
  logic [EE_DW-1:0] wrd_data;
  logic             tick, sh_start, sh_poll, sh_done, sh_idle;
  frame_t           sh_frame;
  logic [CNT_W-1:0] sh_nbits;
  logic [EE_DW-1:0] sh_rx;

  assign busy    = rl_flag | st_flag;
  assign cpu_ok  = cpu_wr && !busy && !boot_q && !soft_rst;
  assign wr_ctrl = cpu_ok && (cpu_addr == 2'd0);
  assign go_rl   = ee_en && (boot_q || (wr_ctrl && cpu_wdata[0]));
  assign go_st   = ee_en && wr_ctrl && !cpu_wdata[0] && cpu_wdata[1];
  assign go_word = !boot_q && cpu_wdata[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q <= 1'b1; rl_flag <= 1'b0; st_flag <= 1'b0;
      wmode_q <= 1'b0; wdata_q <= '0; waddr_q <= '0;
    end else begin
      boot_q <= 1'b0;
      if (go_rl) rl_flag <= 1'b1; else if (eng_done) rl_flag <= 1'b0;
      if (go_st) st_flag <= 1'b1; else if (eng_done) st_flag <= 1'b0;
      if (soft_rst && !busy && !boot_q) begin
        wmode_q <= 1'b0; wdata_q <= '0; waddr_q <= '0;
      end else if (cpu_ok) begin
        case (cpu_addr)
          2'd0: wmode_q <= cpu_wdata[2];
          2'd1: wdata_q <= cpu_wdata;
          2'd2: waddr_q <= cpu_wdata[EE_AW-1:0];
          default: ;
        endcase
      end
      if (wrd_we) wdata_q <= wrd_data;
    end
  end

  always_comb begin
    cpu_rdata = '0;
    if (cpu_addr == 2'd0) cpu_rdata[2:0] = {wmode_q, st_flag, rl_flag};
    else if (!busy) begin
      if (cpu_addr == 2'd1) cpu_rdata = wdata_q;
      else if (cpu_addr == 2'd2) cpu_rdata[EE_AW-1:0] = waddr_q;
    end
  end

  ee_tick #(.CLK_DIV(CLK_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

  ee_seq #(
    .NWORDS(NWORDS), .DFLT_SEL(DFLT_SEL), .DFLT_BASE(DFLT_BASE), .DFLT_IRQ(DFLT_IRQ)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go_rl | go_st), .go_store(go_st), .go_word(go_word),
    .area(area_sel), .w_addr(waddr_q), .w_data(wdata_q), .cfg_rdata(cfg_rdata),
    .busy(eng_busy), .done(eng_done), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .wrd_we(wrd_we), .wrd_data(wrd_data),
    .sh_start(sh_start), .sh_poll(sh_poll), .sh_frame(sh_frame), .sh_nbits(sh_nbits),
    .sh_done(sh_done), .sh_rx(sh_rx)
  );

  ee_shift u_shift (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(sh_start), .poll(sh_poll),
    .frame(sh_frame), .nbits(sh_nbits), .din(ee_do), .idle(sh_idle), .done(sh_done),
    .rx(sh_rx), .cs(ee_cs), .sk(ee_sk), .di(ee_di)
  );

  AST_FLAGS_TRACK_ENGINE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy == busy); // R6
  AST_ONE_OPERATION: assert property (@(posedge clk) disable iff (!rst_n)
    !(rl_flag && st_flag)); // R6
  AST_CFG_ONLY_ON_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> (rl_flag && !wmode_q)); // R2
  AST_REGS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cpu_wr) |=> ($stable(waddr_q) && $stable(wmode_q))); // R7
  AST_NO_CS_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ee_en && !busy) |-> !ee_cs); // R9
  AST_SHIFT_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    sh_start |-> sh_idle); // R5
endmodule

// File: tb/eeprom_cfg_loader_test.sv
module eeprom_cfg_loader_test;
  localparam int CD = 4;
  localparam int NW = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0, soft_rst = 1'b0, ee_en = 1'b1;
  logic [2:0]  area_sel = 3'd3;
  logic [1:0]  cpu_addr = 2'd0;
  logic        cpu_wr = 1'b0;
  logic [15:0] cpu_wdata = '0, cpu_rdata;
  logic        cfg_we;
  logic [2:0]  cfg_idx;
  logic [15:0] cfg_wdata, cfg_rdata;
  logic        ee_cs, ee_sk, ee_di, ee_do;
  logic [15:0] cfg_arr [8];

  assign cfg_rdata = cfg_arr[cfg_idx];

  eeprom_cfg_loader #(.CLK_DIV(CD), .NWORDS(NW)) uut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .ee_en(ee_en), .area_sel(area_sel),
    .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
  );

  // serial EEPROM model
  logic [15:0] mem [64];
  logic [24:0] msh = '0;
  int          mcnt = 0, nwr = 0, nwen = 0;
  logic        rd_act = 1'b0, do_r = 1'b0, wen = 1'b0;
  logic [15:0] rdw = '0;

  always @(posedge ee_sk or negedge ee_cs) begin
    if (!ee_cs) begin
      if (mcnt == 9 && msh[8:4] == 5'b10011) begin wen = 1'b1; nwen++; end
      if (mcnt == 25 && msh[24:22] == 3'b101 && wen) begin
        mem[msh[21:16]] = msh[15:0]; nwr++;
      end
      mcnt = 0; rd_act = 1'b0; msh = '0;
    end else begin
      msh = {msh[23:0], ee_di}; mcnt++;
      if (mcnt == 9 && msh[8:6] == 3'b110) begin rd_act = 1'b1; rdw = mem[msh[5:0]]; do_r = 1'b0; end
      else if (rd_act && mcnt >= 10 && mcnt <= 25) do_r = rdw[25-mcnt];
    end
  end

  int bseen = 0, bcnt = 0;
  always @(posedge clk) begin
    if (nwr != bseen) begin bseen = nwr; bcnt = 30; end
    else if (bcnt > 0) bcnt--;
  end
  assign ee_do = rd_act ? do_r : ((bcnt > 0) ? 1'b0 : 1'b1);

  // monitors
  logic [15:0] got [8];
  int ncfg = 0, cs_bad = 0, sk_bad = 0, hi_runs = 0, hi_len = 0, cs_rises = 0;
  logic sk_prev = 1'b0, cs_prev = 1'b0;
  always @(negedge clk) begin
    if (cfg_we === 1'b1) begin got[cfg_idx] = cfg_wdata; ncfg++; end
    if (ee_sk === 1'b1 && ee_cs !== 1'b1) cs_bad++;
    if (ee_sk === 1'b1) hi_len++;
    else if (sk_prev) begin hi_runs++; if (hi_len != CD) sk_bad++; hi_len = 0; end
    if (ee_cs === 1'b1 && !cs_prev) cs_rises++;
    sk_prev = (ee_sk === 1'b1);
    cs_prev = (ee_cs === 1'b1);
  end

  int vecs = 0, errs = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_cfg(input int sel, input int i);
    if (sel == 7 && i == 0) return 16'h0300;
    if (sel == 7 && i == 1) return 16'h0002;
    return mem[sel*8 + i];
  endfunction

  task automatic cpu_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk); cpu_wr = 1'b0;
  endtask

  task automatic cpu_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); cpu_addr = a; #1; d = cpu_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    for (int k = 0; k < 40000; k++) begin
      cpu_read(2'd0, v);
      if (v[1:0] == 2'b00) return;
    end
  endtask

  task automatic do_reset(input logic en);
    rst_n = 1'b0; ee_en = en;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic check_reload(input string tag, input int sel);
    chk({tag, " count"}, ncfg, NW);
    for (int i = 0; i < NW; i++) chk(tag, got[i], exp_cfg(sel, i));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog actual=hang expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int base_nwr, base_nwen, base_cs;
    void'($urandom(32'd20511));
    for (int i = 0; i < 64; i++) mem[i] = 16'($urandom);
    for (int i = 0; i < 8; i++) begin cfg_arr[i] = 16'($urandom); got[i] = '0; end

    // R1 / R2 / R4: reset reload
    area_sel = 3'd3;
    do_reset(1'b1);
    cpu_read(2'd0, v); chk("R1 reload flag after reset", v, 16'h0001);
    wait_idle();
    check_reload("R2 reset reload", 3);
    chk("R4 shift clock high phase", sk_bad, 0);
    chk("R4 sk only under cs", cs_bad, 0);
    chk("R4 clock seen", (hi_runs > 0), 1);

    // R2 / R3: random areas and contents
    for (int it = 0; it < 5; it++) begin
      area_sel = 3'($urandom);
      for (int i = 0; i < 8; i++) mem[area_sel*8 + i] = 16'($urandom);
      ncfg = 0;
      cpu_write(2'd0, 16'h0001);
      wait_idle();
      check_reload("R2 R3 random reload", int'(area_sel));
    end

    // R3: default area directed
    area_sel = 3'd7; ncfg = 0;
    cpu_write(2'd0, 16'h0001); wait_idle();
    chk("R3 default base", got[0], 16'h0300);
    chk("R3 default irq", got[1], 16'h0002);
    chk("R3 other word", got[2], mem[58]);

    // R7: lockout
    area_sel = 3'd1;
    cpu_write(2'd0, 16'h0001);
    cpu_write(2'd2, 16'h002A);
    cpu_read(2'd1, v); chk("R7 read blocked while busy", v, 16'h0000);
    cpu_write(2'd0, 16'h0004);
    wait_idle();
    cpu_read(2'd2, v); chk("R7 address write ignored", v, 16'h0000);
    cpu_read(2'd0, v); chk("R7 control write ignored", v, 16'h0000);

    // R8: word read
    cpu_write(2'd2, 16'h0015);
    ncfg = 0;
    cpu_write(2'd0, 16'h0005);
    wait_idle();
    cpu_read(2'd1, v); chk("R8 word read", v, mem[21]);
    chk("R8 no cfg writes", ncfg, 0);
    cpu_read(2'd0, v); chk("R8 word mode kept", v, 16'h0004);

    // R8 / R5 / R6: word write
    base_nwen = nwen; v = mem[22];
    cpu_write(2'd1, 16'hBEEF);
    cpu_write(2'd0, 16'h0006);
    begin
      logic [15:0] c;
      cpu_read(2'd0, c); chk("R6 store flag", c, 16'h0006);
    end
    wait_idle();
    chk("R8 word written", mem[21], 16'hBEEF);
    chk("R8 neighbour kept", mem[22], v);
    chk("R5 enable frame", nwen - base_nwen, 1);

    // R5: full store
    cpu_write(2'd0, 16'h0000);
    area_sel = 3'd2; ncfg = 0;
    base_nwr = nwr; base_nwen = nwen; v = mem[16 + NW];
    cpu_write(2'd0, 16'h0002);
    wait_idle();
    for (int i = 0; i < NW; i++) chk("R5 stored word", mem[16 + i], cfg_arr[i]);
    chk("R5 write count", nwr - base_nwr, NW);
    chk("R5 enable count", nwen - base_nwen, NW);
    chk("R5 word past area kept", mem[16 + NW], v);
    chk("R5 no cfg writes", ncfg, 0);

    // R6: both bits
    ncfg = 0; base_nwr = nwr;
    cpu_write(2'd0, 16'h0003);
    cpu_read(2'd0, v); chk("R6 reload wins", v, 16'h0001);
    wait_idle();
    for (int i = 0; i < NW; i++) chk("R6 reload data", got[i], cfg_arr[i]);
    chk("R6 no store", nwr - base_nwr, 0);

    // R10: soft reset
    cpu_write(2'd2, 16'h0005);
    cpu_write(2'd1, 16'h1234);
    cpu_write(2'd0, 16'h0004);
    base_cs = cs_rises;
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    repeat (50) @(negedge clk);
    cpu_read(2'd1, v); chk("R10 data cleared", v, 16'h0000);
    cpu_read(2'd2, v); chk("R10 address cleared", v, 16'h0000);
    cpu_read(2'd0, v); chk("R10 control clear", v, 16'h0000);
    chk("R10 no transfer", cs_rises - base_cs, 0);

    // R9: EEPROM disabled
    base_cs = cs_rises; ncfg = 0;
    do_reset(1'b0);
    cpu_read(2'd0, v); chk("R9 no reset reload", v, 16'h0000);
    cpu_write(2'd0, 16'h0001);
    cpu_read(2'd0, v); chk("R9 reload ignored", v, 16'h0000);
    cpu_write(2'd0, 16'h0002);
    cpu_read(2'd0, v); chk("R9 store ignored", v, 16'h0000);
    repeat (200) @(negedge clk);
    chk("R9 cs never rose", cs_rises - base_cs, 0);
    chk("R9 no cfg writes", ncfg, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule